// File: doc/BRIEF.md
# Reference switch phase-step corrector

This block sits in front of a digital PLL and feeds it a virtual reference. The virtual reference is made from one of two reference clocks, primary or secondary. The chosen reference passes through a counter-based delay line. All timing is counted in ticks of a fast sampling clock. A reference edge is the rising transition of the chosen input as seen at a sampling-clock edge. Each virtual reference edge is a one-tick pulse.

When the selection changes, the block does the following in order:

1. It raises a holdover flag, which tells the PLL to coast.
2. It waits for the PLL feedback edge.
3. It counts ticks from that feedback edge to the next edge of the newly chosen reference.
4. It folds the count into one nominal reference period and loads the complement as the new delay.
5. It drops holdover.

Virtual reference edges then keep falling on the feedback grid, so the PLL sees no phase step. The nominal period comes from a two-bit rate code. If the new reference stays silent for too long, the block remains in holdover and flags the loss.

Top module: `refsw_phase_corrector`

## Requirements
- R1: `ref_sel` = 0 routes the primary input and 1 routes the secondary input. Edges on the input that is not routed never produce a `vref` pulse.
- R2: With `corr_en` low, the added delay is zero. A selection change raises no holdover. Lowering `corr_en` drops `holdover` and `ref_fail` on the next clock.
- R3: `vref` is a one-cycle pulse. With zero delay it is high in the cycle after the clock edge that first samples the routed input high. With delay D it comes exactly D cycles later.
- R4: A change of `ref_sel` while `corr_en` is high sets `holdover` from the next cycle. Reference edges seen before the feedback edge take no part in the measurement, and holdover stays set.
- R5: Let m be the number of clock edges from the feedback edge to the new reference edge, with m = 0 when both are seen at the same edge. The block loads D = (P − (m mod P)) mod P, where P is the nominal period. Holdover clears at that same edge, and that reference edge is already delayed by D.
- R6: A reference edge is accepted while m ≤ 2P. If none arrives by then, `ref_fail` rises 2P cycles after the feedback edge and `holdover` stays high. Later edges are ignored until the next selection change, which clears `ref_fail`.
- R7: `dly_clr` sets the delay to zero. It wins over a measurement load in the same cycle, and holdover still ends.
- R8: `freq_sel` code 00 selects P = `P_8K`, 01 selects `P_T1` and 10 selects `P_E1`. Code 11 keeps the previous period and raises `freq_err` on the next cycle, for as long as 11 is applied.
- R9: After reset, `vref`, `holdover`, `ref_fail` and `freq_err` are low, the delay is zero and the period is `P_8K`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, the tick for all timing |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pri | input | 1 | Primary reference clock |
| ref_sec | input | 1 | Secondary reference clock |
| ref_sel | input | 1 | Reference choice, 0 primary, 1 secondary |
| corr_en | input | 1 | Enables the phase-step correction |
| dly_clr | input | 1 | Forces the delay to zero |
| fb_edge | input | 1 | One-cycle pulse marking the PLL feedback edge |
| freq_sel | input | 2 | Nominal reference rate code |
| vref | output | 1 | Virtual reference pulse to the PLL |
| holdover | output | 1 | PLL must ignore vref while high |
| ref_fail | output | 1 | New reference missing after a switch |
| freq_err | output | 1 | Reserved rate code applied |

## Verification
The delay clear and the load of a freshly measured delay can land on the same clock edge. The bench provokes this by raising `dly_clr` in the very cycle that the new reference edge ends a measurement. It then judges the outcome: holdover must drop at that edge, and the same reference edge must reach `vref` at once, showing that the clear overrode the measured value. A second overlap is also tested: the feedback edge and the new reference edge arrive together, which must load a zero delay.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
   typedef enum logic [1:0] {
      ST_TRACK    = 2'b00,
      ST_AWAIT_FB = 2'b01,
      ST_MEASURE  = 2'b10,
      ST_LOST     = 2'b11
   } ctl_state_t;

   typedef enum logic [1:0] {
      RATE_8K   = 2'b00,
      RATE_T1   = 2'b01,
      RATE_E1   = 2'b10,
      RATE_RSVD = 2'b11
   } rate_code_t;
endpackage

// File: rtl/refsw_edge_det.sv
module refsw_edge_det #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic pulse
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse = sig & ~prev_q;
      end else begin : g_fall
         assign pulse = ~sig & prev_q;
      end
   endgenerate
endmodule

// File: rtl/refsw_rate_cfg.sv
module refsw_rate_cfg
   import refsw_pkg::*;
#(
   parameter int TW   = 15,
   parameter int P_8K = 8192,
   parameter int P_T1 = 42,
   parameter int P_E1 = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    freq_sel,
   output logic [TW-1:0] per,
   output logic          freq_err
);
   rate_code_t code;
   assign code = rate_code_t'(freq_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per      <= TW'(P_8K);
         freq_err <= 1'b0;
      end else begin
         freq_err <= (code == RATE_RSVD);
         case (code)
            RATE_8K: per <= TW'(P_8K);
            RATE_T1: per <= TW'(P_T1);
            RATE_E1: per <= TW'(P_E1);
            default: per <= per;
         endcase
      end
   end
endmodule

// File: rtl/refsw_delay_line.sv
module refsw_delay_line #(
   parameter int TW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig,
   input  logic [TW-1:0] dly,
   output logic          pulse
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pulse <= 1'b0;
      end else if (trig) begin
         cnt_q <= dly;
         pulse <= (dly == '0);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         pulse <= (cnt_q == TW'(1));
      end else begin
         pulse <= 1'b0;
      end
   end
endmodule

// File: rtl/refsw_switch_ctrl.sv
module refsw_switch_ctrl
   import refsw_pkg::*;
#(
   parameter int TW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          en,
   input  logic          clr,
   input  logic          fb,
   input  logic          ref_edge,
   input  logic [TW-1:0] per,
   output logic [TW-1:0] dly_nxt,
   output logic [TW-1:0] dly_q,
   output logic          holdover,
   output logic          ref_fail
);
   ctl_state_t    state_q, state_d;
   logic [TW-1:0] cnt_q, cnt_d;
   logic          sel_q;
   logic          fail_q, fail_d;
   logic          load;
   logic [TW-1:0] meas, per2, folded, dcalc;

   assign per2 = {per[TW-2:0], 1'b0};

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      fail_d  = fail_q;
      load    = 1'b0;
      meas    = '0;
      if (!en) begin
         state_d = ST_TRACK;
         fail_d  = 1'b0;
      end else if (sel != sel_q) begin
         state_d = ST_AWAIT_FB;
         fail_d  = 1'b0;
      end else begin
         case (state_q)
            ST_AWAIT_FB: if (fb) begin
               if (ref_edge) begin
                  load    = 1'b1;
                  state_d = ST_TRACK;
               end else begin
                  state_d = ST_MEASURE;
                  cnt_d   = TW'(1);
               end
            end
            ST_MEASURE: begin
               if (ref_edge) begin
                  load    = 1'b1;
                  meas    = cnt_q;
                  state_d = ST_TRACK;
               end else if (cnt_q >= per2) begin
                  state_d = ST_LOST;
                  fail_d  = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      if (meas >= per2)     folded = meas - per2;
      else if (meas >= per) folded = meas - per;
      else                  folded = meas;
      dcalc = (folded == '0) ? '0 : per - folded;
      if (clr)       dly_nxt = '0;
      else if (load) dly_nxt = dcalc;
      else           dly_nxt = dly_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_TRACK;
         cnt_q   <= '0;
         sel_q   <= sel;
         fail_q  <= 1'b0;
         dly_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         sel_q   <= sel;
         fail_q  <= fail_d;
         dly_q   <= dly_nxt;
      end
   end

   assign holdover = (state_q != ST_TRACK);
   assign ref_fail = fail_q;
endmodule

// File: rtl/refsw_phase_corrector.sv
module refsw_phase_corrector #(
   parameter int P_8K   = 8192,
   parameter int P_T1   = 42,
   parameter int P_E1   = 32,
   parameter bit RISING = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_pri,
   input  logic       ref_sec,
   input  logic       ref_sel,
   input  logic       corr_en,
   input  logic       dly_clr,
   input  logic       fb_edge,
   input  logic [1:0] freq_sel,
   output logic       vref,
   output logic       holdover,
   output logic       ref_fail,
   output logic       freq_err
);
   localparam int PMAX = (P_8K > P_T1) ? ((P_8K > P_E1) ? P_8K : P_E1)
                                       : ((P_T1 > P_E1) ? P_T1 : P_E1);
   localparam int TW   = $clog2(2 * PMAX + 1);
   localparam int NREF = 2;

   generate
      if (P_E1 < 2 || P_T1 < 2 || P_8K < 2) begin : g_bad_period
         $error("refsw_phase_corrector: every period must be at least two ticks");
      end
   endgenerate

   logic [NREF-1:0] ref_vec, edge_vec;
   logic [TW-1:0]   per, dly_nxt, dly_q, eff_dly;
   logic            sel_edge;

   assign ref_vec = {ref_sec, ref_pri};

   generate
      for (genvar i = 0; i < NREF; i++) begin : g_edge
         refsw_edge_det #(.RISING(RISING)) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .sig   (ref_vec[i]),
            .pulse (edge_vec[i])
         );
      end
   endgenerate

   assign sel_edge = edge_vec[ref_sel];

   refsw_rate_cfg #(.TW(TW), .P_8K(P_8K), .P_T1(P_T1), .P_E1(P_E1)) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .freq_sel (freq_sel),
      .per      (per),
      .freq_err (freq_err)
   );

   refsw_switch_ctrl #(.TW(TW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (ref_sel),
      .en       (corr_en),
      .clr      (dly_clr),
      .fb       (fb_edge),
      .ref_edge (sel_edge),
      .per      (per),
      .dly_nxt  (dly_nxt),
      .dly_q    (dly_q),
      .holdover (holdover),
      .ref_fail (ref_fail)
   );

   assign eff_dly = corr_en ? dly_nxt : '0;

   refsw_delay_line #(.TW(TW)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (sel_edge),
      .dly   (eff_dly),
      .pulse (vref)
   );
endmodule

// File: rtl/refsw_checker.sv
module refsw_checker #(
   parameter int TW = 15
) (
   input logic          clk,
   input logic          rst_n,
   input logic          corr_en,
   input logic          ref_sel,
   input logic          dly_clr,
   input logic [1:0]    freq_sel,
   input logic          holdover,
   input logic          ref_fail,
   input logic          freq_err,
   input logic [TW-1:0] dly_q
);
   a_r2_disable_exits: assert property (@(posedge clk) disable iff (!rst_n)
      !corr_en |=> !holdover);

   a_r4_switch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (corr_en && !$stable(ref_sel)) |=> holdover);

   a_r6_fail_in_holdover: assert property (@(posedge clk) disable iff (!rst_n)
      ref_fail |-> holdover);

   a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      dly_clr |=> (dly_q == '0));

   a_r8_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_sel == 2'b11) |=> freq_err);
endmodule

bind refsw_phase_corrector refsw_checker #(.TW(TW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .corr_en  (corr_en),
   .ref_sel  (ref_sel),
   .dly_clr  (dly_clr),
   .freq_sel (freq_sel),
   .holdover (holdover),
   .ref_fail (ref_fail),
   .freq_err (freq_err),
   .dly_q    (dly_q)
);

// File: tb/sim_refsw_phase_corrector.sv
`timescale 1ns/1ps
module sim_refsw_phase_corrector;
   localparam int P8 = 40, PT = 14, PE = 10;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       ref_pri = 0, ref_sec = 0, ref_sel = 0, corr_en = 0, dly_clr = 0, fb_edge = 0;
   logic [1:0] freq_sel = 2'b00;
   logic       vref, holdover, ref_fail, freq_err;
   int         n_chk = 0, n_bad = 0;
   bit         done = 0;

   always #2.5 clk = ~clk;

   refsw_phase_corrector #(.P_8K(P8), .P_T1(PT), .P_E1(PE)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_pri(ref_pri), .ref_sec(ref_sec), .ref_sel(ref_sel),
      .corr_en(corr_en), .dly_clr(dly_clr), .fb_edge(fb_edge), .freq_sel(freq_sel),
      .vref(vref), .holdover(holdover), .ref_fail(ref_fail), .freq_err(freq_err)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_delay(input int m, input int p);
      int r = m % p;
      return (r == 0) ? 0 : p - r;
   endfunction

   task automatic set_ref(input bit which, input bit v);
      if (which) ref_sec = v; else ref_pri = v;
   endtask

   task automatic pulse_ref(input bit which);
      set_ref(which, 1'b1);
      tick();
      set_ref(which, 1'b0);
   endtask

   task automatic ticks_to_vref(output int n);
      n = 0;
      while (!vref && n < 300) begin
         tick();
         n++;
      end
   endtask

   // Switch, feedback edge, new reference edge m ticks later; early adds a stray edge before fb.
   task automatic run_switch(input bit nsel, input int m, input int p, input bit early,
                             input bit clr_at_edge, input string req);
      int n;
      ref_sel = nsel;
      tick();
      check("R4 holdover after switch", holdover, 1);
      if (early) begin
         tick();
         pulse_ref(nsel);
         tick();
         check("R4 stray edge before feedback ignored", holdover, 1);
         repeat (p) tick();
      end
      fb_edge = 1'b1;
      if (m == 0) begin
         set_ref(nsel, 1'b1);
         dly_clr = clr_at_edge;
      end
      tick();
      fb_edge = 1'b0;
      if (m > 0) begin
         repeat (m - 1) tick();
         set_ref(nsel, 1'b1);
         dly_clr = clr_at_edge;
         tick();
      end
      set_ref(nsel, 1'b0);
      dly_clr = 1'b0;
      check({req, " holdover released"}, holdover, 0);
      ticks_to_vref(n);
      check({req, " delay on switching edge"}, n, clr_at_edge ? 0 : exp_delay(m, p));
      tick();
      check("R3 pulse is one cycle", vref, 0);
   endtask

   task automatic t_reset();
      check("R9 vref", vref, 0);
      check("R9 holdover", holdover, 0);
      check("R9 ref_fail", ref_fail, 0);
      check("R9 freq_err", freq_err, 0);
   endtask

   task automatic t_disabled();
      corr_en = 0;
      ref_sel = 0;
      tick();
      pulse_ref(0);
      check("R2 zero delay when disabled", vref, 1);
      tick();
      check("R3 single cycle", vref, 0);
      ref_sel = 1;
      tick();
      check("R2 no holdover when disabled", holdover, 0);
      pulse_ref(1);
      check("R1 secondary routed", vref, 1);
      tick();
      pulse_ref(0);
      check("R1 unrouted primary ignored", vref, 0);
      tick();
      check("R1 unrouted primary ignored later", vref, 0);
   endtask

   task automatic t_rates();
      freq_sel = 2'b10;
      tick();
      check("R8 valid code no error", freq_err, 0);
      freq_sel = 2'b11;
      tick();
      check("R8 reserved code flags", freq_err, 1);
      tick();
      check("R8 flag held while reserved", freq_err, 1);
   endtask

   task automatic t_switching();
      int n;
      corr_en = 1;
      tick();
      // reserved code kept P = PE
      run_switch(0, 3, PE, 0, 0, "R5 R8 kept period");
      freq_sel = 2'b10;
      tick();
      check("R8 error clears", freq_err, 0);
      repeat (4) tick();
      pulse_ref(0);
      ticks_to_vref(n);
      check("R3 steady delay reused", n, exp_delay(3, PE));
      tick();
      run_switch(1, 12, PE, 1, 0, "R4 R5 wrap above period");
      run_switch(0, 0, PE, 0, 0, "R5 same-cycle edge");
      run_switch(1, PE, PE, 0, 0, "R5 one full period");
      run_switch(0, 2 * PE, PE, 0, 0, "R6 latest accepted edge");
      run_switch(1, 2 * PE - 1, PE, 0, 0, "R5 just under two periods");
      freq_sel = 2'b00;
      tick();
      run_switch(0, 5, P8, 0, 0, "R8 R5 slow rate");
      freq_sel = 2'b01;
      tick();
      run_switch(1, 3, PT, 0, 0, "R8 R5 mid rate");
   endtask

   task automatic t_clear();
      int n;
      dly_clr = 1;
      tick();
      dly_clr = 0;
      tick();
      pulse_ref(1);
      ticks_to_vref(n);
      check("R7 clear zeroes delay", n, 0);
      tick();
      run_switch(0, 4, PT, 0, 1, "R7 clear wins over load");
   endtask

   task automatic t_timeout();
      freq_sel = 2'b10;
      tick();
      ref_sel = 1;
      tick();
      fb_edge = 1;
      tick();
      fb_edge = 0;
      repeat (2 * PE - 1) tick();
      check("R6 no fail before limit", ref_fail, 0);
      tick();
      check("R6 fail at limit", ref_fail, 1);
      check("R6 holdover kept", holdover, 1);
      pulse_ref(1);
      tick();
      check("R6 late edge ignored", holdover, 1);
      ref_sel = 0;
      tick();
      check("R6 new switch clears fail", ref_fail, 0);
      check("R4 new switch holds", holdover, 1);
      corr_en = 0;
      tick();
      check("R2 disable drops holdover", holdover, 0);
   endtask

   initial begin
      repeat (3) tick();
      t_reset();
      rst_n = 1;
      tick();
      t_disabled();
      t_rates();
      t_switching();
      t_clear();
      t_timeout();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule